// File: doc/BRIEF.md
# Pipelined Short-Float Adder/Subtracter

This block adds or subtracts two 18-bit floating point words and returns one packed 18-bit result. A word holds a sign bit in bit 17, an excess-63 exponent in bits 16 down to 10, and a 10-bit fraction in bits 9 down to 0. The fraction carries an implicit leading one, so a word stands for (-1)^sign × 2^(exp-63) × 1.frac. Neither infinities, NaNs nor denormals exist in this format. Results are truncated, never rounded.

A new operand pair and an operation select may enter on every clock edge, each qualified by a valid strobe. The work is split across three registered stages. The first stage orders the operands by magnitude and measures their exponent gap. The second aligns the smaller significand and adds or subtracts it. The third finds the leading one and normalizes the result. A result leaves exactly three edges after its operands were taken, and a full pipeline delivers one result per cycle. Exact cancellation gives the all-zero word. Exponent underflow is clamped to the all-zero word, and exponent overflow is clamped to the largest magnitude.

Top module: `fpa_addsub`

## Requirements
- R1: Adding 0x10E03 (24.046875) and 0x30E5A (-25.40625) gives 0x2FD70 (-1.359375). The result exponent falls from 67 to 63 during normalization.
- R2: `out_valid` is high on the cycle that follows the third rising edge after an edge where `in_valid` was high, and low otherwise. `out_sum` is the result for the operands taken at that edge.
- R3: Operand pairs presented on consecutive edges give results on consecutive cycles, in the same order.
- R4: With `in_sub` = 1, the sign of `in_b` is inverted before the operation. With `in_sub` = 0, `in_b` is used as given.
- R5: The operands are ordered by the magnitude field (bits 16:0). The result sign is the sign of the operand with the larger magnitude, after the R4 inversion.
- R6: The smaller significand is shifted right by the exponent gap, and the bits shifted out are discarded (truncation).
- R7: When the exponent gap is 16 or more, the aligned operand becomes zero, and the result equals the larger operand.
- R8: When the significand sum carries out, the result is shifted right by one bit and the exponent goes up by one.
- R9: When subtraction leaves leading zeros, the significand is shifted left until its top bit is set, and the shift count is taken off the exponent.
- R10: A significand result of zero gives the all-zero word (positive sign).
- R11: When the normalized exponent would fall below 0, the result is the all-zero word. An exponent of exactly 0 is kept.
- R12: When a carry pushes the exponent past 127, the result saturates to exponent 127 and fraction 0x3FF, and the sign is kept.
- R13: While `rst` is high, `out_valid` and `out_sum` are held at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies the operands and select on this edge |
| in_a | input | 18 | First operand word |
| in_b | input | 18 | Second operand word |
| in_sub | input | 1 | 0 selects a + b, 1 selects a - b |
| out_valid | output | 1 | Result word is valid |
| out_sum | output | 18 | Packed result word |

## Verification
Some conditions fall in the same cycle of the last stage. A carry out of the significand add can meet an exponent already at 127, so the increment and the overflow clamp must be resolved together. A large left normalization shift can meet a small exponent, so the shift and the underflow clamp act at once. Both pairs are provoked with operand words chosen to land on each side of the limit: exponent 126 against 127 for the carry case, and exponent 11 against 2 for the normalization case. Each result is compared with a word worked out by hand. The alignment path is also tested at an exact truncation and with a gap far beyond the shifter's reach.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

  // Operation select carried into stage 1
  typedef enum logic {
    FPA_OP_ADD = 1'b0,
    FPA_OP_SUB = 1'b1
  } fpa_op_e;

  // Default field widths of the short-float word
  localparam int FPA_EXP_W_DEF  = 7;
  localparam int FPA_FRAC_W_DEF = 10;

endpackage

// File: rtl/fpa_order.sv
// Stage 1 logic: effective sign, magnitude ordering, exponent gap.
module fpa_order
  import fpa_pkg::*;
#(
  parameter  int EXP_W  = FPA_EXP_W_DEF,
  parameter  int FRAC_W = FPA_FRAC_W_DEF,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int SIG_W  = FRAC_W + 1
) (
  input  logic [WORD_W-1:0] a_word,
  input  logic [WORD_W-1:0] b_word,
  input  fpa_op_e           op,
  output logic              big_sign,
  output logic              small_sign,
  output logic [EXP_W-1:0]  big_exp,
  output logic [EXP_W-1:0]  exp_gap,
  output logic [SIG_W-1:0]  big_sig,
  output logic [SIG_W-1:0]  small_sig
);

  logic             b_sign_eff;
  logic             a_wins;
  logic [EXP_W-1:0] small_exp;

  assign b_sign_eff = b_word[WORD_W-1] ^ (op == FPA_OP_SUB);

  // Exponent sits above fraction, so one unsigned compare orders magnitudes
  assign a_wins = a_word[WORD_W-2:0] >= b_word[WORD_W-2:0];

  always_comb begin
    if (a_wins) begin
      big_sign   = a_word[WORD_W-1];
      small_sign = b_sign_eff;
      big_exp    = a_word[WORD_W-2:FRAC_W];
      small_exp  = b_word[WORD_W-2:FRAC_W];
      big_sig    = {1'b1, a_word[FRAC_W-1:0]};
      small_sig  = {1'b1, b_word[FRAC_W-1:0]};
    end else begin
      big_sign   = b_sign_eff;
      small_sign = a_word[WORD_W-1];
      big_exp    = b_word[WORD_W-2:FRAC_W];
      small_exp  = a_word[WORD_W-2:FRAC_W];
      big_sig    = {1'b1, b_word[FRAC_W-1:0]};
      small_sig  = {1'b1, a_word[FRAC_W-1:0]};
    end
  end

  assign exp_gap = big_exp - small_exp;

endmodule

// File: rtl/fpa_align_add.sv
// Stage 2 logic: saturating logarithmic right shift, then add or subtract.
module fpa_align_add #(
  parameter  int EXP_W  = 7,
  parameter  int FRAC_W = 10,
  localparam int SIG_W  = FRAC_W + 1,
  localparam int SUM_W  = SIG_W + 1,
  localparam int SH_W   = $clog2(SIG_W + 1)
) (
  input  logic              big_sign,
  input  logic              small_sign,
  input  logic [EXP_W-1:0]  exp_gap,
  input  logic [SIG_W-1:0]  big_sig,
  input  logic [SIG_W-1:0]  small_sig,
  output logic [SUM_W-1:0]  sum
);

  logic [SH_W-1:0]  shamt;
  logic [SIG_W-1:0] stg [SH_W+1];
  logic             add_mode;

  // Any gap bit above the shifter range forces the largest shift
  assign shamt = (|exp_gap[EXP_W-1:SH_W]) ? {SH_W{1'b1}} : exp_gap[SH_W-1:0];

  assign stg[0] = small_sig;
  for (genvar k = 0; k < SH_W; k++) begin : g_rsh
    assign stg[k+1] = shamt[k] ? (stg[k] >> (2 ** k)) : stg[k];
  end

  assign add_mode = (big_sign == small_sign);

  always_comb begin
    if (add_mode) sum = {1'b0, big_sig} + {1'b0, stg[SH_W]};
    else          sum = {1'b0, big_sig} - {1'b0, stg[SH_W]};
  end

endmodule

// File: rtl/fpa_normalize.sv
// Stage 3 logic: leading-one search, left shift, exponent fix-up and clamps.
module fpa_normalize #(
  parameter  int EXP_W  = 7,
  parameter  int FRAC_W = 10,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int SIG_W  = FRAC_W + 1,
  localparam int SUM_W  = SIG_W + 1,
  localparam int LZ_W   = $clog2(SIG_W),
  localparam int XW     = EXP_W + 1
) (
  input  logic              sign_in,
  input  logic [EXP_W-1:0]  exp_in,
  input  logic [SUM_W-1:0]  sum_in,
  output logic [WORD_W-1:0] word_out
);

  logic [LZ_W-1:0]  lead_pos;
  logic             any_one;
  logic [LZ_W-1:0]  lz;
  logic [SIG_W-1:0] lstg [LZ_W+1];
  logic             carry;

  // Priority search: highest set bit of the non-carry part wins
  always_comb begin
    lead_pos = '0;
    any_one  = 1'b0;
    for (int i = 0; i < SIG_W; i++) begin
      if (sum_in[i]) begin
        lead_pos = LZ_W'(i);
        any_one  = 1'b1;
      end
    end
  end

  assign lz    = LZ_W'(SIG_W - 1) - lead_pos;
  assign carry = sum_in[SUM_W-1];

  assign lstg[0] = sum_in[SIG_W-1:0];
  for (genvar k = 0; k < LZ_W; k++) begin : g_lsh
    assign lstg[k+1] = lz[k] ? (lstg[k] << (2 ** k)) : lstg[k];
  end

  always_comb begin
    if (carry) begin
      if (exp_in == {EXP_W{1'b1}})
        word_out = {sign_in, {EXP_W{1'b1}}, {FRAC_W{1'b1}}};
      else
        word_out = {sign_in, exp_in + 1'b1, sum_in[SIG_W-1:1]};
    end else if (!any_one) begin
      word_out = '0;
    end else if (XW'(lz) > {1'b0, exp_in}) begin
      word_out = '0;
    end else begin
      word_out = {sign_in, exp_in - EXP_W'(lz), lstg[LZ_W][FRAC_W-1:0]};
    end
  end

endmodule

// File: rtl/fpa_addsub.sv
// Three-stage short-float adder/subtracter, top level.
module fpa_addsub
  import fpa_pkg::*;
#(
  parameter  int EXP_W  = FPA_EXP_W_DEF,
  parameter  int FRAC_W = FPA_FRAC_W_DEF,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int SIG_W  = FRAC_W + 1,
  localparam int SUM_W  = SIG_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  input  logic              in_sub,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_sum
);

  // Stage 1 combinational results
  logic             c1_big_sign, c1_small_sign;
  logic [EXP_W-1:0] c1_big_exp, c1_gap;
  logic [SIG_W-1:0] c1_big_sig, c1_small_sig;

  // Stage 1 registers
  logic             s1_valid;
  logic             s1_big_sign, s1_small_sign;
  logic [EXP_W-1:0] s1_big_exp, s1_gap;
  logic [SIG_W-1:0] s1_big_sig, s1_small_sig;

  // Stage 2
  logic [SUM_W-1:0] c2_sum;
  logic             s2_valid;
  logic             s2_sign;
  logic [EXP_W-1:0] s2_exp;
  logic [SUM_W-1:0] s2_sum;

  // Stage 3
  logic [WORD_W-1:0] c3_word;

  fpa_order #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_order (
    .a_word     (in_a),
    .b_word     (in_b),
    .op         (fpa_op_e'(in_sub)),
    .big_sign   (c1_big_sign),
    .small_sign (c1_small_sign),
    .big_exp    (c1_big_exp),
    .exp_gap    (c1_gap),
    .big_sig    (c1_big_sig),
    .small_sig  (c1_small_sig)
  );

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= in_valid;
    s1_big_sign   <= c1_big_sign;
    s1_small_sign <= c1_small_sign;
    s1_big_exp    <= c1_big_exp;
    s1_gap        <= c1_gap;
    s1_big_sig    <= c1_big_sig;
    s1_small_sig  <= c1_small_sig;
  end

  fpa_align_add #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
    .big_sign   (s1_big_sign),
    .small_sign (s1_small_sign),
    .exp_gap    (s1_gap),
    .big_sig    (s1_big_sig),
    .small_sig  (s1_small_sig),
    .sum        (c2_sum)
  );

  always_ff @(posedge clk) begin
    if (rst) s2_valid <= 1'b0;
    else     s2_valid <= s1_valid;
    s2_sign <= s1_big_sign;
    s2_exp  <= s1_big_exp;
    s2_sum  <= c2_sum;
  end

  fpa_normalize #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
    .sign_in  (s2_sign),
    .exp_in   (s2_exp),
    .sum_in   (s2_sum),
    .word_out (c3_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
    end else begin
      out_valid <= s2_valid;
      out_sum   <= c3_word;
    end
  end

endmodule

// File: rtl/fpa_addsub_chk.sv
// Property checker attached to the adder/subtracter top.
module fpa_addsub_chk #(
  parameter  int EXP_W  = 7,
  parameter  int FRAC_W = 10,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int SH_W   = $clog2(FRAC_W + 2)
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [WORD_W-1:0] in_a,
  input logic [WORD_W-1:0] in_b,
  input logic              in_sub,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_sum
);

  logic [1:0] warm;
  logic       far_gap;

  always_ff @(posedge clk) begin
    if (rst)               warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  assign far_gap = int'(in_a[WORD_W-2:FRAC_W]) >= int'(in_b[WORD_W-2:FRAC_W]) + (2 ** SH_W);

  AST_LATENCY_VALID: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R2

  AST_ZERO_POSITIVE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sum[WORD_W-2:0] == '0) |-> !out_sum[WORD_W-1]); // R10

  AST_SELF_CANCEL: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && $past(in_valid && in_sub && in_a == in_b, 3)) |-> (out_sum == '0)); // R4

  AST_LIKE_SIGN: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && $past(in_valid && !in_sub && in_a[WORD_W-1] == in_b[WORD_W-1], 3))
    |-> (out_sum[WORD_W-1] == $past(in_a[WORD_W-1], 3))); // R5

  AST_FAR_OPERAND: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3 && $past(in_valid && !in_sub && far_gap, 3)) |-> (out_sum == $past(in_a, 3))); // R7

endmodule

bind fpa_addsub fpa_addsub_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_a      (in_a),
  .in_b      (in_b),
  .in_sub    (in_sub),
  .out_valid (out_valid),
  .out_sum   (out_sum)
);

// File: tb/test_fpa_addsub.sv
`timescale 1ns/1ps
module test_fpa_addsub;

  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic         in_sub = 1'b0;
  logic         out_valid;
  logic [W-1:0] out_sum;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fpa_addsub i_fpa_addsub (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .in_sub    (in_sub),
    .out_valid (out_valid),
    .out_sum   (out_sum)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual 0x%05h expected 0x%05h", req, act, exp_v);
    end
  endtask

  // One operation in isolation: latency and value
  task automatic run_op(input string req, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic sub, input logic [W-1:0] exp_v);
    @(negedge clk);
    in_a = a; in_b = b; in_sub = sub; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check({req, " early valid"}, W'(out_valid), W'(0));
    @(negedge clk);
    check({req, " valid"}, W'(out_valid), W'(1));
    check(req, out_sum, exp_v);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R13 valid in reset", W'(out_valid), W'(0));
    check("R13 sum in reset", out_sum, W'(0));
    rst = 1'b0;
  endtask

  task automatic t_example;   // R1, R9
    run_op("R1 R9 worked example", 18'h10E03, 18'h30E5A, 1'b0, 18'h2FD70);
  endtask

  task automatic t_subtract;  // R4: 3.0 - 1.0 = 2.0, and 1.0 - 1.0 = 0
    run_op("R4 sub select", 18'h10200, 18'h0FC00, 1'b1, 18'h10000);
    run_op("R4 R10 self cancel", 18'h0FC00, 18'h0FC00, 1'b1, 18'h00000);
  endtask

  task automatic t_order;     // R5: 1.0 + (-3.0) = -2.0
    run_op("R5 swap sign", 18'h0FC00, 18'h30200, 1'b0, 18'h30000);
  endtask

  task automatic t_align;     // R6 truncation, R7 far gap
    run_op("R6 truncate", 18'h0FC00, 18'h0F001, 1'b0, 18'h0FC80);
    run_op("R7 far gap", 18'h19000, 18'h343FF, 1'b0, 18'h19000);
  endtask

  task automatic t_carry;     // R8, R12
    run_op("R8 carry 1.5+1.5", 18'h0FE00, 18'h0FE00, 1'b0, 18'h10200);
    run_op("R8 carry to top exp", 18'h1F800, 18'h1F800, 1'b0, 18'h1FC00);
    run_op("R12 saturate pos", 18'h1FFFF, 18'h1FFFF, 1'b0, 18'h1FFFF);
    run_op("R12 saturate neg", 18'h3FFFF, 18'h3FFFF, 1'b0, 18'h3FFFF);
  endtask

  task automatic t_underflow; // R11
    run_op("R11 underflow", 18'h00801, 18'h20800, 1'b0, 18'h00000);
    run_op("R11 exponent 1 kept", 18'h02C01, 18'h22C00, 1'b0, 18'h00400);
  endtask

  task automatic t_stream;    // R3, R2
    @(negedge clk);
    in_a = 18'h10E03; in_b = 18'h30E5A; in_sub = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    in_a = 18'h0FE00; in_b = 18'h0FE00; in_sub = 1'b0;
    @(negedge clk);
    in_a = 18'h0FC00; in_b = 18'h10200; in_sub = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R3 stream valid 0", W'(out_valid), W'(1));
    check("R3 stream result 0", out_sum, 18'h2FD70);
    @(negedge clk);
    check("R3 stream result 1", out_sum, 18'h10200);
    @(negedge clk);
    check("R3 stream result 2", out_sum, 18'h30000);
    @(negedge clk);
    check("R2 gap valid low", W'(out_valid), W'(0));
  endtask

  initial begin
    t_reset();
    t_example();
    t_subtract();
    t_order();
    t_align();
    t_carry();
    t_underflow();
    t_stream();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule